// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block raises a periodic interrupt. A prescaler divides the clock by a programmable ratio. Each prescaler tick steps a 16-bit down-counter. When a tick finds the counter at zero, the counter reloads from a separate period register and a one-cycle interrupt pulse is issued. The first interval comes from whatever value was written into the counter, and every later interval comes from the period register, so the two can differ.

Software writes four registers through a single-cycle write port: the live count, the reload period, the prescale value, and a control word whose bit 0 starts or stops counting. The prescale register holds the division ratio minus one, so a value of zero steps the counter on every enabled cycle.

A two-state machine gates the datapath. In state ST_HALT, the prescaler and the counter hold their values. In state ST_COUNT, they advance. The transition GO (ST_HALT to ST_COUNT) is taken on a control write with bit 0 set. The transition STOP (ST_COUNT to ST_HALT) is taken on a control write with bit 0 clear. Any other input keeps the current state.

Top module: `tick_interval_timer`

## Requirements
- R1: After reset, the count, period, scale and prescaler are all zero, the state is ST_HALT (`running` low) and `irq` is low.
- R2: A write with `wr_en` high is decoded by `wr_sel`. Value 0 selects the count, 1 the period, 2 the scale (from `wr_data[7:0]`), and 3 the control word, where `wr_data[0]` is the enable bit. The new state is visible on the following cycle.
- R3: With a scale value S, the counter steps once every S+1 enabled cycles.
- R4: On a prescaler tick with a nonzero count, the count decreases by one, including from 16'hFFFF.
- R5: On a prescaler tick with the count at zero, the count reloads from the period register, and `irq` is high for exactly that cycle. It is seen together with the reloaded count. With period P and scale S, the steady interrupt interval is (P+1)*(S+1) cycles.
- R6: A count write takes effect on the next cycle in either state, and it reloads the prescaler from the scale register. No tick and no interrupt happen in the cycle of the write.
- R7: While in ST_HALT, the prescaler and the count hold their values (except on a count write), and `irq` stays low.
- R8: With period 0 and scale 0, `irq` is high on every enabled cycle once the count is zero.
- R9: A period write does not disturb the running count and is used at the next reload. A scale write does not disturb a prescale cycle in progress and is used at the next prescaler reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 count, 1 period, 2 scale, 3 control |
| wr_data | input | 16 | Write data |
| irq | output | 1 | One-cycle interrupt pulse on reload |
| count_val | output | 16 | Current counter value |
| running | output | 1 | High in state ST_COUNT |

## Verification
The bench builds the timer with its default widths: a 16-bit counter and an 8-bit scale. Small period and scale values make several reloads happen within a few dozen cycles, which exposes the first-interval versus steady-interval difference. A count written as 16'hFFFF reaches the top of the counter range. A scale of 255 reaches the largest prescale ratio in a few hundred cycles. Period 0 with scale 0 brings the back-to-back interrupt case into reach.

// File: rtl/tit_pkg.sv
package tit_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_CTRL   = 2'd3
    } tit_sel_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } tit_state_e;
endpackage

// File: rtl/tit_prescaler.sv
module tit_prescaler #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    logic [SCALE_W-1:0] pre_q;

    // A tick needs an enabled cycle with the prescaler exhausted and no restart.
    assign tick = run && !restart && (pre_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= scale;
        end else if (run) begin
            if (pre_q == '0) pre_q <= scale;
            else             pre_q <= pre_q - 1'b1;
        end
    end

    AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && pre_q != '0) |=> (pre_q == $past(pre_q) - 1'b1)); // R3
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(pre_q)); // R7
    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == $past(scale))); // R6
endmodule

// File: rtl/tit_downcount.sv
module tit_downcount #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = tick && !load && (count == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            if (count == '0) count <= period;
            else             count <= count - 1'b1;
        end
    end

    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && count != '0) |=> (count == $past(count) - 1'b1)); // R4
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count)); // R7
endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer #(
    parameter int CNT_W   = 16,
    parameter int SCALE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq,
    output logic [CNT_W-1:0] count_val,
    output logic             running
);
    import tit_pkg::*;

    tit_state_e         state_q, state_d;
    logic [CNT_W-1:0]   period_q;
    logic [SCALE_W-1:0] scale_q;
    logic               cnt_wr, per_wr, scl_wr, ctl_wr;
    logic               tick, wrap, run;

    assign cnt_wr = wr_en && (tit_sel_e'(wr_sel) == SEL_COUNT);
    assign per_wr = wr_en && (tit_sel_e'(wr_sel) == SEL_PERIOD);
    assign scl_wr = wr_en && (tit_sel_e'(wr_sel) == SEL_SCALE);
    assign ctl_wr = wr_en && (tit_sel_e'(wr_sel) == SEL_CTRL);

    // Next state: GO and STOP follow control writes.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (ctl_wr && wr_data[0])  state_d = ST_COUNT;
            ST_COUNT: if (ctl_wr && !wr_data[0]) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Outputs decoded from state.
    always_comb begin
        unique case (state_q)
            ST_COUNT: run = 1'b1;
            default:  run = 1'b0;
        endcase
    end
    assign running = run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            scale_q  <= '0;
            irq      <= 1'b0;
        end else begin
            if (per_wr) period_q <= wr_data;
            if (scl_wr) scale_q  <= wr_data[SCALE_W-1:0];
            irq <= wrap;
        end
    end

    tit_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (cnt_wr),
        .scale   (scale_q),
        .tick    (tick)
    );

    tit_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (wr_data),
        .tick     (tick),
        .period   (period_q),
        .count    (count_val),
        .wrap     (wrap)
    );

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count_val == $past(period_q))); // R5
    AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(running)); // R7
    AST_LOAD_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(cnt_wr)); // R6
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(count_val)); // R7
    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count_val == $past(wr_data))); // R6
endmodule

// File: tb/tick_interval_timer_tb.sv
`timescale 1ns/1ps
module tick_interval_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        irq;
    logic [15:0] count_val;
    logic        running;

    int tests = 0;
    int fails = 0;
    string tag = "R1";

    // Reference model state.
    int m_cnt, m_per, m_scl, m_pre, m_run, m_irq;

    always #2.5 clk = ~clk;

    tick_interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .irq(irq), .count_val(count_val), .running(running)
    );

    task automatic check(string req, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_step(bit we, int sel, int data);
        int n_cnt = m_cnt, n_pre = m_pre;
        m_irq = 0;
        if (we && sel == 0) begin
            n_cnt = data; n_pre = m_scl;
        end else if (m_run != 0) begin
            if (m_pre == 0) begin
                n_pre = m_scl;
                if (m_cnt == 0) begin n_cnt = m_per; m_irq = 1; end
                else n_cnt = m_cnt - 1;
            end else n_pre = m_pre - 1;
        end
        m_cnt = n_cnt; m_pre = n_pre;
        if (we && sel == 1) m_per = data;
        if (we && sel == 2) m_scl = data & 255;
        if (we && sel == 3) m_run = data & 1;
    endtask

    // One cycle: drive at the falling edge, advance model, compare at next falling edge.
    task automatic cyc(bit we, int sel, int data);
        wr_en = we; wr_sel = sel[1:0]; wr_data = data[15:0];
        model_step(we, sel, data);
        @(negedge clk);
        check(tag, count_val, m_cnt, "count");
        check(tag, irq, m_irq, "irq");
        check(tag, running, m_run, "running");
    endtask

    task automatic idle(int n, output int irqs);
        irqs = 0;
        for (int i = 0; i < n; i++) begin
            cyc(0, 0, 0);
            if (irq) irqs++;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n_irq;
        int held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", count_val, 0, "count after reset");
        check("R1", irq, 0, "irq after reset");
        check("R1", running, 0, "running after reset");
        rst_n = 1'b1;
        m_cnt = 0; m_per = 0; m_scl = 0; m_pre = 0; m_run = 0; m_irq = 0;

        // R2: register writes while halted; R7: nothing moves
        tag = "R2";
        cyc(1, 1, 3);
        cyc(1, 2, 2);
        cyc(1, 0, 5);
        check("R2", count_val, 5, "count write visible");
        tag = "R7";
        idle(8, n_irq);
        check("R7", count_val, 5, "count held while halted");
        check("R7", n_irq, 0, "no irq while halted");

        // R3/R5: count 5, period 3, scale 2 -> irqs at 18,30,42,54
        tag = "R5";
        cyc(1, 3, 1);
        idle(60, n_irq);
        check("R5", n_irq, 4, "irqs in 60 cycles with P=3 S=2");
        check("R3", m_run, 1, "model running");

        // R9: period/scale changes mid-run
        tag = "R9";
        cyc(1, 1, 1);
        idle(7, n_irq);
        cyc(1, 2, 0);
        idle(20, n_irq);

        // R8: period 0 scale 0
        tag = "R8";
        cyc(1, 1, 0);
        cyc(1, 0, 0);
        idle(10, n_irq);
        check("R8", n_irq, 10, "irq every cycle P=0 S=0");

        // R7: stop mid-run with P=7 S=1
        tag = "R7";
        cyc(1, 1, 7);
        cyc(1, 2, 1);
        cyc(1, 0, 4);
        idle(3, n_irq);
        cyc(1, 3, 0);
        held = count_val;
        idle(10, n_irq);
        check("R7", count_val, held, "count held after STOP");
        check("R7", n_irq, 0, "no irq after STOP");
        tag = "R6";
        cyc(1, 0, 9);
        check("R6", count_val, 9, "count write while halted");
        cyc(1, 3, 1);
        idle(5, n_irq);

        // R4: top of range
        tag = "R4";
        cyc(1, 2, 0);
        cyc(1, 0, 16'hFFFF);
        idle(3, n_irq);
        check("R4", count_val, 16'hFFFC, "decrement from FFFF");

        // R3: largest scale, count 1 period 1 -> one irq at cycle 512
        tag = "R3";
        cyc(1, 1, 1);
        cyc(1, 2, 255);
        cyc(1, 0, 1);
        idle(300, n_irq);
        check("R3", count_val, 0, "one step after 256 cycles at S=255");
        idle(220, n_irq);
        check("R3", n_irq, 1, "irq after 512 cycles at S=255");

        // R6: count write suppresses irq in its cycle
        tag = "R6";
        cyc(1, 2, 0);
        cyc(1, 1, 0);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        check("R6", irq, 0, "no irq on count write cycle");
        idle(2, n_irq);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule